// File: doc/BRIEF.md
# CHS Sector Address Sequencer

This block turns a cylinder/head/sector request into a linear block address for a fixed-geometry disk drive. It then walks through consecutive sectors for a transfer that spans several of them. The drive geometry (cylinder count, head count and sectors per track) arrives on input ports. The block keeps its own record of where the heads physically sit. Head movement comes from three commands: seek to a cylinder, park on the innermost cylinder, and return to cylinder zero. A transfer command checks the request against the geometry and against the physical position before it produces any address. The block does not move data. A companion data engine pulses `next` once it has handled each sector, and it stops when `done` rises.

A small state machine controls the sequencing. It has three states:
- `S_IDLE` waits for `start`.
- `S_XFER` holds an accepted transfer and waits for `next` strobes.
- `S_DONE` is a single-cycle completion state. It drives `done` and always returns to `S_IDLE`.

The transitions are:
- IDLE→XFER on a transfer that passes all checks.
- IDLE→DONE on any positioning command or on a rejected transfer.
- XFER→DONE on the last sector's `next` or on a cylinder overflow.
- XFER→XFER on any other `next`.
- DONE→IDLE always.

Top module: `chs_seq`

## Requirements
- R1: After reset, `busy`, `done`, `seek_end`, all three error flags, `lba` and `pos_cyl` are all zero.
- R2: A transfer (`op`=0) whose requested cylinder differs from `pos_cyl` is rejected. In the cycle after `start`, `err_wrong_cyl`=1 and `done`=1, with no other error flag set and `busy`=0. This check outranks the head and sector checks.
- R3: For a transfer on the correct cylinder, a head number ≥ `geo_heads` sets `err_cyl` alone, together with `done`. This check outranks the sector check.
- R4: For a transfer on the correct cylinder with a valid head, a sector number > `geo_spt` sets `err_mark` alone, together with `done`.
- R5: An accepted transfer sets `busy`=1 in the cycle after `start`. In that cycle `lba` = ((cyl·heads)+head)·spt + sector − 1, with sectors numbered from 1.
- R6: Each `next` that is not for the last sector advances the sector in the cycle after the strobe. Past `geo_spt` the sector wraps to 1 and the head increments. Past the last head, the head wraps to 0 and `pos_cyl` increments. `lba` rises by one on each such step.
- R7: `last_sector` is high while exactly one sector remains. A `next` in that state gives `done`=1 and `busy`=0 one cycle later, with `lba` unchanged. A count of 0 behaves as a count of 1.
- R8: If a step would move past cylinder `geo_cyls`−1, `pos_cyl` stays clamped at `geo_cyls`−1 and `err_cyl` is set. `done` rises in the same cycle and sequencing halts.
- R9: A seek (`op`=1) to a cylinder below `geo_cyls` moves `pos_cyl` there and sets `seek_end`. A seek to any other cylinder sets `err_cyl` and leaves `pos_cyl` unchanged. Either way, `done` follows one cycle after `start`.
- R10: Park (`op`=2) moves `pos_cyl` to `geo_cyls`−1 and sets `seek_end`. Recalibrate (`op`=3) moves `pos_cyl` to 0 with `seek_end`=0. Both raise `done` one cycle after `start`.
- R11: `start` while `busy` is ignored, which leaves `pos_cyl`, `lba` and `busy` unchanged. `next` outside a transfer is ignored.
- R12: Every accepted `start` clears the error flags and `seek_end` before it evaluates the new command. At most one error flag is ever set. The flags hold their value after `done` until the next accepted `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| geo_cyls | input | CYL_W | Number of cylinders |
| geo_heads | input | HEAD_W+1 | Number of heads |
| geo_spt | input | SEC_W | Sectors per track |
| start | input | 1 | Command strobe, accepted in S_IDLE |
| op | input | 2 | 0 transfer, 1 seek, 2 park, 3 recalibrate |
| req_cyl | input | CYL_W | Requested cylinder (transfer or seek target) |
| req_head | input | HEAD_W | Requested head |
| req_sec | input | SEC_W | Requested sector, 1-based |
| req_count | input | CNT_W | Sector count (0 treated as 1) |
| next | input | 1 | Current sector handled, advance |
| lba | output | LBA_W | Linear block address of the current sector |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| last_sector | output | 1 | One sector remains |
| err_wrong_cyl | output | 1 | Requested cylinder is not the physical one |
| err_cyl | output | 1 | Head out of range, seek out of range, or cylinder overflow |
| err_mark | output | 1 | Sector beyond the track |
| seek_end | output | 1 | Last seek or park completed |
| pos_cyl | output | CYL_W | Physical head position |

## Verification
The bench keeps the default widths: 10-bit cylinder, 4-bit head, 8-bit sector, 8-bit count and 24-bit address. Geometry is a port, so each phase drives a different geometry. Tiny geometries, down to one head and one sector per track, make sector, head and cylinder wraps and the end-of-disk clamp happen within a handful of strobes. A full 1023×16×63 geometry drives the address multiplier to its largest value. Random requests are biased toward the current cylinder, so every accept path and rejection path is exercised.

// File: rtl/chs_pkg.sv
package chs_pkg;

    typedef enum logic [1:0] {
        OP_XFER  = 2'd0,
        OP_SEEK  = 2'd1,
        OP_PARK  = 2'd2,
        OP_RECAL = 2'd3
    } chs_op_e;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_XFER = 2'd1,
        S_DONE = 2'd2
    } chs_state_e;

    typedef struct packed {
        logic wrong_cyl;
        logic cyl_err;
        logic mark_nf;
    } chs_err_t;

endpackage

// File: rtl/chs_check.sv
module chs_check
    import chs_pkg::*;
#(
    parameter int CYL_W  = 10,
    parameter int HEAD_W = 4,
    parameter int SEC_W  = 8,
    parameter int LBA_W  = 24
) (
    input  logic [CYL_W-1:0]  pos_cyl,
    input  logic [HEAD_W:0]   geo_heads,
    input  logic [SEC_W-1:0]  geo_spt,
    input  logic [CYL_W-1:0]  req_cyl,
    input  logic [HEAD_W-1:0] req_head,
    input  logic [SEC_W-1:0]  req_sec,
    output chs_err_t          err,
    output logic [LBA_W-1:0]  lba
);
    localparam int HN_W = HEAD_W + 1;

    logic [LBA_W-1:0] track_idx;
    logic [LBA_W-1:0] sec_base;

    // Validation order: cylinder match, then head range, then sector range.
    always_comb begin
        err = '0;
        if (req_cyl != pos_cyl) begin
            err.wrong_cyl = 1'b1;
        end else if (HN_W'(req_head) >= geo_heads) begin
            err.cyl_err = 1'b1;
        end else if (req_sec > geo_spt) begin
            err.mark_nf = 1'b1;
        end
    end

    always_comb begin
        track_idx = LBA_W'(req_cyl) * LBA_W'(geo_heads) + LBA_W'(req_head);
        sec_base  = track_idx * LBA_W'(geo_spt);
        lba       = sec_base + LBA_W'(req_sec) - LBA_W'(1);
    end

endmodule

// File: rtl/chs_step.sv
module chs_step #(
    parameter int HEAD_W = 4,
    parameter int SEC_W  = 8
) (
    input  logic [HEAD_W-1:0] cur_head,
    input  logic [SEC_W-1:0]  cur_sec,
    input  logic [HEAD_W:0]   geo_heads,
    input  logic [SEC_W-1:0]  geo_spt,
    output logic [HEAD_W-1:0] nxt_head,
    output logic [SEC_W-1:0]  nxt_sec,
    output logic              cyl_carry
);
    localparam int HN_W = HEAD_W + 1;

    always_comb begin
        nxt_sec   = cur_sec + SEC_W'(1);
        nxt_head  = cur_head;
        cyl_carry = 1'b0;
        if (cur_sec >= geo_spt) begin
            nxt_sec = SEC_W'(1);
            if (HN_W'(cur_head) + HN_W'(1) >= geo_heads) begin
                nxt_head  = '0;
                cyl_carry = 1'b1;
            end else begin
                nxt_head = cur_head + HEAD_W'(1);
            end
        end
    end

endmodule

// File: rtl/chs_position.sv
module chs_position #(
    parameter int CYL_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CYL_W-1:0] geo_cyls,
    input  logic             op_seek,
    input  logic             op_park,
    input  logic             op_recal,
    input  logic             op_step,
    input  logic [CYL_W-1:0] seek_cyl,
    output logic [CYL_W-1:0] pos_cyl,
    output logic             seek_ok,
    output logic             step_ovf
);
    localparam int CP_W = CYL_W + 1;

    assign seek_ok  = seek_cyl < geo_cyls;
    assign step_ovf = (CP_W'(pos_cyl) + CP_W'(1)) >= CP_W'(geo_cyls);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_cyl <= '0;
        end else if (op_recal) begin
            pos_cyl <= '0;
        end else if (op_park) begin
            pos_cyl <= geo_cyls - CYL_W'(1);
        end else if (op_seek && seek_ok) begin
            pos_cyl <= seek_cyl;
        end else if (op_step) begin
            pos_cyl <= step_ovf ? geo_cyls - CYL_W'(1) : pos_cyl + CYL_W'(1);
        end
    end

    // R10
    recal_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_recal |=> pos_cyl == '0);

    // R8
    clamp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_step && step_ovf && !op_seek && !op_park && !op_recal
        |=> pos_cyl == $past(geo_cyls) - CYL_W'(1));

    // R9
    seek_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_seek && !seek_ok && !op_park && !op_recal && !op_step |=> $stable(pos_cyl));

endmodule

// File: rtl/chs_seq.sv
module chs_seq
    import chs_pkg::*;
#(
    parameter int CYL_W  = 10,
    parameter int HEAD_W = 4,
    parameter int SEC_W  = 8,
    parameter int CNT_W  = 8,
    parameter int LBA_W  = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CYL_W-1:0]  geo_cyls,
    input  logic [HEAD_W:0]   geo_heads,
    input  logic [SEC_W-1:0]  geo_spt,
    input  logic              start,
    input  logic [1:0]        op,
    input  logic [CYL_W-1:0]  req_cyl,
    input  logic [HEAD_W-1:0] req_head,
    input  logic [SEC_W-1:0]  req_sec,
    input  logic [CNT_W-1:0]  req_count,
    input  logic              next,
    output logic [LBA_W-1:0]  lba,
    output logic              busy,
    output logic              done,
    output logic              last_sector,
    output logic              err_wrong_cyl,
    output logic              err_cyl,
    output logic              err_mark,
    output logic              seek_end,
    output logic [CYL_W-1:0]  pos_cyl
);
    chs_state_e        state, state_nxt;
    chs_op_e           op_kind;
    chs_err_t          err_q, chk_err;
    logic [LBA_W-1:0]  lba_q, chk_lba;
    logic [HEAD_W-1:0] cur_head, nxt_head;
    logic [SEC_W-1:0]  cur_sec, nxt_sec;
    logic [CNT_W-1:0]  remain;
    logic              seek_end_q;
    logic              cyl_carry, seek_ok, step_ovf;
    logic              accept, step_fire, last_fire, overflow;

    assign op_kind   = chs_op_e'(op);
    assign accept    = start && (state == S_IDLE);
    assign last_fire = (state == S_XFER) && next && (remain <= CNT_W'(1));
    assign step_fire = (state == S_XFER) && next && (remain > CNT_W'(1));
    assign overflow  = step_fire && cyl_carry && step_ovf;

    chs_check #(
        .CYL_W (CYL_W),
        .HEAD_W(HEAD_W),
        .SEC_W (SEC_W),
        .LBA_W (LBA_W)
    ) u_check (
        .pos_cyl  (pos_cyl),
        .geo_heads(geo_heads),
        .geo_spt  (geo_spt),
        .req_cyl  (req_cyl),
        .req_head (req_head),
        .req_sec  (req_sec),
        .err      (chk_err),
        .lba      (chk_lba)
    );

    chs_step #(
        .HEAD_W(HEAD_W),
        .SEC_W (SEC_W)
    ) u_step (
        .cur_head (cur_head),
        .cur_sec  (cur_sec),
        .geo_heads(geo_heads),
        .geo_spt  (geo_spt),
        .nxt_head (nxt_head),
        .nxt_sec  (nxt_sec),
        .cyl_carry(cyl_carry)
    );

    chs_position #(
        .CYL_W(CYL_W)
    ) u_pos (
        .clk     (clk),
        .rst_n   (rst_n),
        .geo_cyls(geo_cyls),
        .op_seek (accept && op_kind == OP_SEEK),
        .op_park (accept && op_kind == OP_PARK),
        .op_recal(accept && op_kind == OP_RECAL),
        .op_step (step_fire && cyl_carry),
        .seek_cyl(req_cyl),
        .pos_cyl (pos_cyl),
        .seek_ok (seek_ok),
        .step_ovf(step_ovf)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nxt;
    end

    // Transitions
    always_comb begin
        state_nxt = state;
        unique case (state)
            S_IDLE: begin
                if (accept) begin
                    if (op_kind == OP_XFER && chk_err == '0) state_nxt = S_XFER;
                    else                                     state_nxt = S_DONE;
                end
            end
            S_XFER: begin
                if (last_fire || overflow) state_nxt = S_DONE;
            end
            S_DONE:  state_nxt = S_IDLE;
            default: state_nxt = S_IDLE;
        endcase
    end

    // Outputs and working registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q      <= '0;
            seek_end_q <= 1'b0;
            lba_q      <= '0;
            cur_head   <= '0;
            cur_sec    <= '0;
            remain     <= '0;
        end else if (accept) begin
            seek_end_q <= 1'b0;
            err_q      <= '0;
            unique case (op_kind)
                OP_XFER: begin
                    err_q <= chk_err;
                    if (chk_err == '0) begin
                        lba_q    <= chk_lba;
                        cur_head <= req_head;
                        cur_sec  <= req_sec;
                        remain   <= (req_count == '0) ? CNT_W'(1) : req_count;
                    end
                end
                OP_SEEK: begin
                    if (seek_ok) seek_end_q <= 1'b1;
                    else         err_q      <= '{wrong_cyl: 1'b0, cyl_err: 1'b1, mark_nf: 1'b0};
                end
                OP_PARK:  seek_end_q <= 1'b1;
                OP_RECAL: seek_end_q <= 1'b0;
                default:  seek_end_q <= 1'b0;
            endcase
        end else if (overflow) begin
            err_q.cyl_err <= 1'b1;
            remain        <= '0;
        end else if (step_fire) begin
            lba_q    <= lba_q + LBA_W'(1);
            cur_head <= nxt_head;
            cur_sec  <= nxt_sec;
            remain   <= remain - CNT_W'(1);
        end else if (last_fire) begin
            remain <= '0;
        end
    end

    assign lba           = lba_q;
    assign busy          = (state == S_XFER);
    assign done          = (state == S_DONE);
    assign last_sector   = busy && (remain == CNT_W'(1));
    assign err_wrong_cyl = err_q.wrong_cyl;
    assign err_cyl       = err_q.cyl_err;
    assign err_mark      = err_q.mark_nf;
    assign seek_end      = seek_end_q;

    // R2
    wrong_cyl_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept && op_kind == OP_XFER && req_cyl != pos_cyl
        |=> done && err_wrong_cyl && !busy);

    // R12
    single_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({err_wrong_cyl, err_cyl, err_mark}));

    // R6
    lba_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step_fire && !overflow |=> lba == $past(lba) + LBA_W'(1));

    // R7
    last_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy && next && last_sector |=> done && !busy);

    // R11
    busy_start_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy && start && !next |=> busy && $stable(pos_cyl));

endmodule

// File: tb/chs_seq_bench.sv
module chs_seq_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [9:0]  geo_cyls = '0;
    logic [4:0]  geo_heads = '0;
    logic [7:0]  geo_spt = '0;
    logic        start = 1'b0;
    logic [1:0]  op = '0;
    logic [9:0]  req_cyl = '0;
    logic [3:0]  req_head = '0;
    logic [7:0]  req_sec = '0;
    logic [7:0]  req_count = '0;
    logic        next = 1'b0;
    logic [23:0] lba;
    logic        busy, done, last_sector, err_wrong_cyl, err_cyl, err_mark, seek_end;
    logic [9:0]  pos_cyl;

    int checks = 0;
    int fails  = 0;
    int g_cyl, g_hd, g_spt, m_pos;

    always #(CLK_PERIOD/2) clk = ~clk;

    chs_seq u_chs_seq (
        .clk(clk), .rst_n(rst_n), .geo_cyls(geo_cyls), .geo_heads(geo_heads),
        .geo_spt(geo_spt), .start(start), .op(op), .req_cyl(req_cyl),
        .req_head(req_head), .req_sec(req_sec), .req_count(req_count), .next(next),
        .lba(lba), .busy(busy), .done(done), .last_sector(last_sector),
        .err_wrong_cyl(err_wrong_cyl), .err_cyl(err_cyl), .err_mark(err_mark),
        .seek_end(seek_end), .pos_cyl(pos_cyl)
    );

    task automatic chk(string req, string what, longint act, longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int exp_lba(int c, int h, int s);
        return ((c * g_hd) + h) * g_spt + s - 1;
    endfunction

    task automatic issue(int k, int c, int h, int s, int n);
        op = 2'(k); req_cyl = 10'(c); req_head = 4'(h); req_sec = 8'(s); req_count = 8'(n);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic pulse_next();
        next = 1'b1;
        @(negedge clk);
        next = 1'b0;
    endtask

    task automatic run_seek(int c);
        bit ok;
        ok = (c < g_cyl);
        issue(1, c, 0, 1, 1);
        if (ok) m_pos = c;
        chk("R9", "seek done", done, 1);
        chk("R9", "seek pos", pos_cyl, m_pos);
        chk("R9", "seek_end", seek_end, ok);
        chk("R9", "seek err_cyl", err_cyl, !ok);
        @(negedge clk);
    endtask

    task automatic run_park();
        issue(2, 0, 0, 1, 1);
        m_pos = g_cyl - 1;
        chk("R10", "park done", done, 1);
        chk("R10", "park pos", pos_cyl, m_pos);
        chk("R10", "park seek_end", seek_end, 1);
        @(negedge clk);
    endtask

    task automatic run_recal();
        issue(3, 0, 0, 1, 1);
        m_pos = 0;
        chk("R10", "recal done", done, 1);
        chk("R10", "recal pos", pos_cyl, 0);
        chk("R10", "recal seek_end", seek_end, 0);
        @(negedge clk);
    endtask

    task automatic set_geo(int c, int h, int s);
        g_cyl = c; g_hd = h; g_spt = s;
        geo_cyls = 10'(c); geo_heads = 5'(h); geo_spt = 8'(s);
        run_recal();
    endtask

    task automatic run_xfer(int c, int h, int s, int n);
        bit ew, ec, em, ovf;
        int rem, cc, ch, cs;
        longint prev;
        ew = (c != m_pos);
        ec = !ew && (h >= g_hd);
        em = !ew && !ec && (s > g_spt);
        issue(0, c, h, s, n);
        if (ew || ec || em) begin
            chk("R2", "reject done", done, 1);
            chk("R2", "err_wrong_cyl", err_wrong_cyl, ew);
            chk("R3", "err_cyl", err_cyl, ec);
            chk("R4", "err_mark", err_mark, em);
            chk("R2", "reject busy", busy, 0);
            @(negedge clk);
            chk("R12", "flags held", {err_wrong_cyl, err_cyl, err_mark}, {ew, ec, em});
            chk("R12", "done pulse", done, 0);
            return;
        end
        chk("R5", "busy", busy, 1);
        chk("R5", "lba", lba, exp_lba(c, h, s));
        chk("R7", "last_sector", last_sector, (n <= 1));
        chk("R12", "flags clear", {err_wrong_cyl, err_cyl, err_mark}, 0);
        rem = (n == 0) ? 1 : n; cc = c; ch = h; cs = s;
        forever begin
            prev = lba;
            pulse_next();
            if (rem == 1) begin
                chk("R7", "final done", done, 1);
                chk("R7", "final busy", busy, 0);
                chk("R7", "final lba", lba, prev);
                chk("R7", "final err", {err_wrong_cyl, err_cyl, err_mark}, 0);
                break;
            end
            cs++; ovf = 0;
            if (cs > g_spt) begin
                cs = 1; ch++;
                if (ch >= g_hd) begin
                    ch = 0;
                    if (m_pos + 1 >= g_cyl) ovf = 1;
                    else begin m_pos++; cc++; end
                end
            end
            if (ovf) begin
                chk("R8", "ovf done", done, 1);
                chk("R8", "ovf err_cyl", err_cyl, 1);
                chk("R8", "ovf pos", pos_cyl, g_cyl - 1);
                break;
            end
            rem--;
            chk("R6", "step lba", lba, exp_lba(cc, ch, cs));
            chk("R6", "step pos", pos_cyl, m_pos);
            chk("R7", "step last", last_sector, (rem == 1));
            chk("R6", "step busy", busy, 1);
        end
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        longint hold;
        void'($urandom(32'h5EC7_0A11));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1", "busy", busy, 0);
        chk("R1", "done", done, 0);
        chk("R1", "lba", lba, 0);
        chk("R1", "pos", pos_cyl, 0);
        chk("R1", "flags", {err_wrong_cyl, err_cyl, err_mark, seek_end}, 0);

        set_geo(4, 2, 3);
        run_xfer(0, 0, 1, 1);
        run_xfer(1, 5, 9, 1);      // R2 priority over head and sector
        run_xfer(0, 2, 9, 1);      // R3 priority over sector
        run_xfer(0, 1, 4, 1);      // R4
        run_xfer(0, 1, 3, 0);      // R7 zero count
        run_seek(1);
        run_xfer(1, 1, 2, 6);      // R6 wraps into next cylinder
        run_seek(3);
        run_xfer(3, 1, 2, 2);      // ends on final sector
        run_xfer(3, 1, 2, 5);      // R8 overflow
        run_seek(4);               // R9 reject
        run_seek(2);
        run_park();
        run_recal();

        // R11 start during busy and next in idle
        issue(0, 0, 0, 1, 2);
        hold = lba;
        issue(1, 2, 0, 1, 1);
        chk("R11", "busy kept", busy, 1);
        chk("R11", "pos kept", pos_cyl, 0);
        chk("R11", "lba kept", lba, hold);
        pulse_next();
        pulse_next();
        chk("R11", "xfer finished", done, 1);
        @(negedge clk);
        hold = lba;
        pulse_next();
        chk("R11", "idle next busy", busy, 0);
        chk("R11", "idle next done", done, 0);
        chk("R11", "idle next lba", lba, hold);

        set_geo(1023, 16, 63);
        run_seek(1022);
        run_xfer(1022, 15, 63, 1);
        run_xfer(1022, 15, 62, 2);
        run_park();

        for (int g = 0; g < 6; g++) begin
            set_geo(2 + $urandom % 7, 1 + $urandom % 4, 1 + $urandom % 5);
            for (int i = 0; i < 30; i++) begin
                int sel;
                sel = $urandom % 10;
                if (sel < 7)
                    run_xfer(($urandom % 5 == 0) ? int'($urandom % g_cyl) : m_pos,
                             $urandom % (g_hd + 1), 1 + $urandom % (g_spt + 1), $urandom % 7);
                else if (sel == 7) run_seek($urandom % (g_cyl + 2));
                else if (sel == 8) run_park();
                else run_recal();
            end
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule